// File: doc/BRIEF.md
# Timeslot Strobe Delay Generator

This block sits beside a PCM port and regenerates the frame-synchronisation signal it receives, shifted in time, so that a second device sharing the same PCM bus can be handed the timeslot that follows. It is a small synchronous machine. It measures the width of each incoming strobe. When the width is legal, it issues a delayed copy of the strobe. When the width is wrong, it raises an error pulse and issues nothing for that frame.

The block has two operating modes, and the mode is picked once after reset. In strobe mode, the clock is the serial bit clock (512 kHz or faster). The input is an active-high strobe that is one 8-bit timeslot wide, and the output is a new 8-bit-wide strobe that starts on the bit boundary where the input strobe ends. In frame-pulse mode, the clock is a 4.096 MHz master clock that runs at two cycles per data bit. The input is an active-low pulse one clock wide, and the output is the same pulse four channel timeslots later, which is 64 clocks. In both modes, the input frame repeats at 8 kHz.

Top module: `tsd_strobe_delay`

## Requirements
- R1: In strobe mode (mode_i = 0), an input strobe sampled high on exactly 8 consecutive rising edges makes strb_o go high at the first rising edge that samples strb_i low again. strb_o then stays high for exactly 8 clock cycles.
- R2: In frame-pulse mode (mode_i = 1), strb_i and strb_o are active low. If strb_i is sampled low on exactly one rising edge n, strb_o is low for exactly one cycle, starting at rising edge n + 64.
- R3: An input strobe of the wrong width makes len_err_o high for exactly one cycle, starting at the rising edge that first samples the strobe inactive, and produces no output strobe. In strobe mode, the wrong width is any width other than 8 samples. In frame-pulse mode, it is any width of more than 1 sample.
- R4: While rst_n is low, len_err_o is 0 and strb_o sits at the inactive level of mode_i (low for strobe mode, high for frame-pulse mode). A strobe that is already active when reset ends is ignored: it gives neither an output nor an error. Only a strobe whose start follows an inactive sample is measured.
- R5: mode_i is captured at the first rising edge after rst_n goes high. Changing mode_i after that edge has no effect until the next reset.
- R6: In frame-pulse mode, a valid pulse that is detected while an earlier pulse is still waiting out its delay replaces the earlier one. Only the later pulse gives an output.
- R7: In frame-pulse mode, a valid pulse may be detected on the same edge at which an earlier pulse's output fires, for example with inputs 63 cycles apart. In that case the earlier output still appears, and the later pulse gets its own output 64 cycles after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock (strobe mode) or 4.096 MHz master clock (frame-pulse mode) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 = strobe mode, 1 = frame-pulse mode; captured once after reset |
| strb_i | input | 1 | Incoming strobe or frame pulse |
| strb_o | output | 1 | Delayed strobe or frame pulse |
| len_err_o | output | 1 | One-cycle pulse when an input strobe has the wrong width |

## Verification
In frame-pulse mode, the detection of a new pulse can land on the same edge at which the delay timer fires an earlier pulse's output. These are two separate actions, and both must happen. The bench provokes this by sending two frame pulses exactly 63 clocks apart. It then judges the full output trace against an expectation built from the requirements: one low cycle 64 clocks after each input pulse. A second scenario, with pulses 27 clocks apart, checks that a pending output is dropped when no such coincidence occurs.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

    typedef enum logic [1:0] {
        TMR_IDLE = 2'd0,
        TMR_WAIT = 2'd1,
        TMR_ACT  = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/tsd_strobe_meter.sv
module tsd_strobe_meter #(
    parameter int SLOT_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic fp_mode_i,
    input  logic strb_i,
    output logic start_o,
    output logic err_o
);
    localparam int RUN_MAX = SLOT_BITS + 1;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);

    typedef struct packed {
        logic             armed;
        logic [RUN_W-1:0] run;
        logic             err;
    } meter_t;

    meter_t q, d;
    logic             act_in;
    logic [RUN_W-1:0] want;

    always_comb begin
        act_in  = fp_mode_i ? ~strb_i : strb_i;
        want    = fp_mode_i ? RUN_W'(1) : RUN_W'(SLOT_BITS);
        d       = q;
        d.err   = 1'b0;
        start_o = 1'b0;
        if (en_i) begin
            if (!q.armed) begin
                if (!act_in) begin
                    d.armed = 1'b1;
                end
            end else if (act_in) begin
                if (q.run != RUN_W'(RUN_MAX)) begin
                    d.run = q.run + 1'b1;
                end
            end else begin
                if (q.run != '0) begin
                    if (q.run == want) begin
                        start_o = 1'b1;
                    end else begin
                        d.err = 1'b1;
                    end
                end
                d.run = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign err_o = q.err;

    // R3: an error flag never lasts longer than one cycle
    p_err_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

endmodule

// File: rtl/tsd_delay_timer.sv
module tsd_delay_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] delay_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             act_o
);
    import tsd_pkg::*;

    typedef struct packed {
        tmr_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             act;
    } tmr_t;

    tmr_t q, d;
    logic fire;

    always_comb begin
        fire = (q.st == TMR_WAIT) && (q.cnt == '0);
        d    = q;
        case (q.st)
            TMR_WAIT: begin
                if (q.cnt == '0) begin
                    d.act = 1'b1;
                    d.cnt = width_i - 1'b1;
                    d.st  = TMR_ACT;
                end else begin
                    d.act = 1'b0;
                    d.cnt = q.cnt - 1'b1;
                end
            end
            TMR_ACT: begin
                if (q.cnt == '0) begin
                    d.act = 1'b0;
                    d.st  = TMR_IDLE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: begin
                d.act = 1'b0;
                d.st  = TMR_IDLE;
            end
        endcase
        if (start_i) begin
            if (delay_i == '0) begin
                d.st  = TMR_ACT;
                d.cnt = width_i - 1'b1;
                d.act = 1'b1;
            end else begin
                d.st  = TMR_WAIT;
                d.cnt = delay_i - 1'b1;
                d.act = fire;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: TMR_IDLE, cnt: '0, act: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign act_o = q.act;

    // R1: the output only becomes active from a start request or an expiring wait
    p_act_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_o) |-> ($past(start_i) || $past(q.st == TMR_WAIT)));

endmodule

// File: rtl/tsd_strobe_delay.sv
module tsd_strobe_delay #(
    parameter int SLOT_BITS      = 8,
    parameter int FP_CLK_PER_BIT = 2,
    parameter int FP_SLOT_GAP    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    input  logic strb_i,
    output logic strb_o,
    output logic len_err_o
);
    localparam int FP_DELAY = SLOT_BITS * FP_CLK_PER_BIT * FP_SLOT_GAP;
    localparam int MAX_CNT  = (FP_DELAY > SLOT_BITS) ? FP_DELAY : SLOT_BITS;
    localparam int CNT_W    = $clog2(MAX_CNT + 1);

    typedef struct packed {
        logic init;
        logic fp;
    } ctl_t;

    ctl_t q, d;
    logic             init_q;
    logic             fp_q;
    logic             start_w;
    logic             act_w;
    logic [CNT_W-1:0] delay_sel;
    logic [CNT_W-1:0] width_sel;

    always_comb begin
        d = q;
        if (!q.init) begin
            d.init = 1'b1;
            d.fp   = mode_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign init_q = q.init;
    assign fp_q   = q.fp;

    // Width measurement ends one edge after a one-clock frame pulse, hence one less.
    assign delay_sel = fp_q ? CNT_W'(FP_DELAY - 1) : '0;
    assign width_sel = fp_q ? CNT_W'(1) : CNT_W'(SLOT_BITS);

    tsd_strobe_meter #(
        .SLOT_BITS (SLOT_BITS)
    ) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (init_q),
        .fp_mode_i (fp_q),
        .strb_i    (strb_i),
        .start_o   (start_w),
        .err_o     (len_err_o)
    );

    tsd_delay_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_w),
        .delay_i (delay_sel),
        .width_i (width_sel),
        .act_o   (act_w)
    );

    assign strb_o = init_q ? (fp_q ? ~act_w : act_w) : mode_i;

    // R5: captured mode never changes once latched
    p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        init_q |=> $stable(fp_q));

    // R2: a frame-pulse output lasts a single clock
    p_fp_one_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (init_q && fp_q && !strb_o) |=> strb_o);

    // R3: an error report in strobe mode never coincides with a new output
    p_err_no_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (init_q && !fp_q && len_err_o) |-> !$rose(strb_o));

    // R4: no error before the mode has been captured
    p_quiet_pre_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !init_q |-> !len_err_o);

    // R1: a strobe-mode output begins right after the input falls
    p_ssi_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (init_q && !fp_q && $rose(strb_o)) |-> (!$past(strb_i) && $past(strb_i, 2)));

endmodule

// File: tb/tb_tsd_strobe_delay.sv
`timescale 1ns/1ps
module tb_tsd_strobe_delay;
    localparam int SLOT   = 8;
    localparam int FP_LAG = 64;
    localparam int NTMAX  = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_i = 1'b0;
    logic strb_i = 1'b0;
    logic strb_o;
    logic len_err_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    bit drv   [NTMAX];
    bit e_act [NTMAX];
    bit e_err [NTMAX];

    always #2.5 clk = ~clk;

    tsd_strobe_delay dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .strb_i    (strb_i),
        .strb_o    (strb_o),
        .len_err_o (len_err_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit legal_len(input bit fp, input int len);
        return fp ? (len == 1) : (len == SLOT);
    endfunction

    task automatic clear_plan();
        for (int i = 0; i < NTMAX; i++) begin
            drv[i] = 1'b0; e_act[i] = 1'b0; e_err[i] = 1'b0;
        end
    endtask

    // Pulse driven from iteration s, sampled on seq edges s..s+len-1.
    task automatic add_pulse(input bit fp, input int s, input int len);
        for (int i = 0; i < len; i++) drv[s + i] = 1'b1;
        if (legal_len(fp, len)) begin
            if (fp) e_act[s + FP_LAG + 1] = 1'b1;
            else for (int k = 0; k < SLOT; k++) e_act[s + SLOT + 1 + k] = 1'b1;
        end else begin
            e_err[s + len + 1] = 1'b1;
        end
    endtask

    task automatic do_reset(input bit fp, input bit leftover);
        @(negedge clk);
        rst_n  = 1'b0;
        mode_i = fp;
        strb_i = leftover ? ~fp : fp;
        repeat (3) @(negedge clk);
        check(strb_o === fp && len_err_o === 1'b0, "R4", "reset level",
              {strb_o, len_err_o}, {fp, 1'b0});
        rst_n = 1'b1;
    endtask

    task automatic run_seq(input bit fp, input string req, input int nt, input bit flip);
        int bad = 0;
        int first = -1;
        int got = 0;
        int want = 0;
        for (int t = 0; t < nt; t++) begin
            bit oa;
            @(negedge clk);
            oa = fp ? ~strb_o : strb_o;
            if (oa !== e_act[t] || len_err_o !== e_err[t]) begin
                bad++;
                if (first < 0) begin
                    first = t;
                    got  = {oa, len_err_o};
                    want = {e_act[t], e_err[t]};
                end
            end
            strb_i = drv[t] ? ~fp : fp;
            if (flip && t >= 1) mode_i = 1'($urandom % 2);
        end
        mode_i = fp;
        check(bad == 0, req, $sformatf("trace at step %0d ({act,err})", first), got, want);
    endtask

    initial begin
        void'($urandom(32'd20240611));

        // ---------------- strobe mode ----------------
        do_reset(1'b0, 1'b0);
        clear_plan(); add_pulse(0, 3, 8);
        run_seq(0, "R1", 30, 0);

        clear_plan(); add_pulse(0, 3, 7); add_pulse(0, 20, 9); add_pulse(0, 40, 8);
        run_seq(0, "R3", 65, 0);

        clear_plan(); add_pulse(0, 3, 8); add_pulse(0, 12, 8);
        run_seq(0, "R1", 40, 0);

        clear_plan(); add_pulse(0, 3, 1); add_pulse(0, 10, 15);
        run_seq(0, "R3", 40, 0);

        for (int r = 0; r < 8; r++) begin
            clear_plan();
            add_pulse(0, 3,  6 + int'($urandom % 5));
            add_pulse(0, 28, 6 + int'($urandom % 5));
            add_pulse(0, 53, 6 + int'($urandom % 5));
            run_seq(0, "R1/R3 random", 80, 0);
        end

        do_reset(1'b0, 1'b1);
        clear_plan();
        for (int i = 0; i < 5; i++) drv[i] = 1'b1;
        add_pulse(0, 12, 8);
        run_seq(0, "R4", 40, 0);

        do_reset(1'b0, 1'b0);
        clear_plan(); add_pulse(0, 3, 8); add_pulse(0, 25, 1); add_pulse(0, 40, 8);
        run_seq(0, "R5", 70, 1);

        // ---------------- frame-pulse mode ----------------
        do_reset(1'b1, 1'b0);
        clear_plan(); add_pulse(1, 3, 1);
        run_seq(1, "R2", 80, 0);

        clear_plan(); add_pulse(1, 3, 2); add_pulse(1, 10, 1);
        run_seq(1, "R3", 85, 0);

        clear_plan(); add_pulse(1, 3, 1); add_pulse(1, 30, 1);
        e_act[3 + FP_LAG + 1] = 1'b0;
        run_seq(1, "R6", 105, 0);

        clear_plan(); add_pulse(1, 3, 1); add_pulse(1, 66, 1);
        run_seq(1, "R7", 140, 0);

        for (int r = 0; r < 4; r++) begin
            int s2;
            s2 = 73 + int'($urandom % 20);
            clear_plan();
            add_pulse(1, 3,  1 + int'($urandom % 2));
            add_pulse(1, s2, 1 + int'($urandom % 2));
            run_seq(1, "R2/R3 random", s2 + 70, 0);
        end

        do_reset(1'b1, 1'b0);
        clear_plan(); add_pulse(1, 3, 1); add_pulse(1, 80, 3);
        run_seq(1, "R5", 90, 1);

        do_reset(1'b1, 1'b1);
        clear_plan();
        for (int i = 0; i < 4; i++) drv[i] = 1'b1;
        add_pulse(1, 10, 1);
        run_seq(1, "R4", 85, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule